// File: doc/BRIEF.md
# Chained Frame Descriptor Fetcher

This block is the per-channel front end of a display DMA engine. Each time a frame begins it decides where the next frame descriptor lives. That address comes from a one-shot branch request when one is pending, and from the stored next-descriptor pointer otherwise. The block checks that the whole 16-byte descriptor lies inside one of the permitted memory windows, then reads the four descriptor words over a simple word read port, one request at a time, and latches them.

Once the descriptor is held, the block checks the frame source address. A zero or out-of-window source raises a bus-error event tagged with the channel number, and nothing is transferred. A descriptor flagged as a palette load produces a palette strobe. Any other descriptor starts pixel transfer, and the command bits decide whether start-of-frame and end-of-frame events accompany it. The pixel mover downstream reports completion through a frame-done strobe. All events are single-cycle pulses meant for a separate interrupt block.

Top module: `frame_desc_fetch`

## Requirements
- R1: A descriptor is four 32-bit words read at base+0, +4, +8 and +12. They are latched in that order as next-descriptor pointer, frame source address, frame ID and command word.
- R2: A write to the branch register (reg_sel_i=1) keeps bits 31:4 and 1:0 and clears bits 3:2.
- R3: At an accepted frame start with branch bit 0 set, the descriptor is fetched from the branch address (bits 31:4, low nibble zero) and branch bit 0 clears. A branch event pulses only when branch bit 1 is also set. With bit 0 clear, the next-descriptor pointer is used.
- R4: The next-descriptor pointer always has bits 3:0 at zero, whether it is loaded by a register write (reg_sel_i=0) or by descriptor word 0.
- R5: A descriptor is fetched only when all 16 bytes fit inside one window (addr >= base and addr+16 <= base+size). Otherwise no memory request is made, the source stays zero and a bus-error event follows.
- R6: Every accepted frame start clears the source address. With chan_en_i low, nothing else happens: no request and no event.
- R7: After the fetch, a source address that is zero or lies outside every window raises ev_ber_o with ber_chan_o equal to the channel number, and no transfer or palette strobe is issued.
- R8: For a valid non-palette frame, xfer_go_o pulses, and ev_sof_o pulses in the same cycle only if command bit 22 is set. The next frame_done_i pulses ev_eof_o only if command bit 21 is set.
- R9: With command bit 26 set, a valid frame produces only pal_go_o: no start, end or transfer event. The next frame_done_i has no effect.
- R10: At most one memory read is outstanding, and mem_req_o and mem_addr_o hold until mem_rvalid_i. busy_o is high from the accepted frame start until the fourth word is latched, and stays low when the fetch is skipped. A frame start while the engine is not idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chan_en_i | input | 1 | Channel enable, sampled at frame start |
| frame_start_i | input | 1 | Frame start strobe |
| frame_done_i | input | 1 | Pixel transfer complete strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 1 | 0 = next-descriptor register, 1 = branch register |
| reg_wdata_i | input | AW | Register write data |
| mem_req_o | output | 1 | Word read request |
| mem_addr_o | output | AW | Word read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | AW | Read data |
| busy_o | output | 1 | Descriptor fetch in progress |
| next_desc_o | output | AW | Next-descriptor pointer |
| branch_o | output | AW | Branch register |
| src_addr_o | output | AW | Frame source address |
| frame_id_o | output | AW | Frame ID word |
| cmd_o | output | AW | Command word |
| xfer_go_o | output | 1 | Start pixel transfer pulse |
| pal_go_o | output | 1 | Start palette load pulse |
| ev_sof_o | output | 1 | Start-of-frame event |
| ev_eof_o | output | 1 | End-of-frame event |
| ev_bs_o | output | 1 | Branch-status event |
| ev_ber_o | output | 1 | Bus-error event |
| ber_chan_o | output | CH_W | Channel tag of the last bus error |

## Verification
The assertions check on every cycle that the pointer and branch registers keep their masked bits, that a held request stays stable with its address inside a window, and that a branch event follows a branch register holding both low bits. They also check that every start, end, palette and bus-error pulse agrees with the latched command word and with the other strobes. Only the bench scenarios can show the outcomes that depend on memory contents: the descriptor words landing in the right fields, the right address chosen at the window boundary, skipped fetches issuing no request, and ignored frame starts leaving the event stream unchanged.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_CHECK, ST_XFER} fdf_state_e;

  localparam int unsigned DESC_WORDS  = 4;
  localparam int unsigned DESC_BYTES  = DESC_WORDS * 4;
  localparam int unsigned CMD_EOF_BIT = 21;
  localparam int unsigned CMD_SOF_BIT = 22;
  localparam int unsigned CMD_PAL_BIT = 26;
  localparam int unsigned BR_REQ_BIT  = 0;
  localparam int unsigned BR_INT_BIT  = 1;
endpackage

// File: rtl/fdf_win_chk.sv
module fdf_win_chk #(
  parameter int unsigned     AW   = 32,
  parameter logic [AW-1:0]   BASE = '0,
  parameter logic [AW-1:0]   SIZE = '0,
  parameter int unsigned     SPAN = 1
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  localparam logic [AW:0] LIMIT  = {1'b0, BASE} + {1'b0, SIZE};
  localparam logic [AW:0] SPAN_X = (AW+1)'(SPAN);

  logic [AW:0] a_ext;
  assign a_ext = {1'b0, addr_i};
  assign hit_o = (a_ext >= {1'b0, BASE}) && ((a_ext + SPAN_X) <= LIMIT);
endmodule

// File: rtl/fdf_desc_regs.sv
module fdf_desc_regs import fdf_pkg::*; #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [AW-1:0]    wr_data_i,
  input  logic             clr_src_i,
  input  logic             clr_bra_i,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [AW-1:0]    ld_data_i,
  output logic [AW-1:0]    next_o,
  output logic [AW-1:0]    branch_o,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    id_o,
  output logic [AW-1:0]    cmd_o
);
  localparam logic [AW-1:0] ALIGN_MASK = ~(AW'(DESC_BYTES - 1));
  localparam logic [AW-1:0] BR_MASK    = ALIGN_MASK | AW'(3);

  logic ld_w0, ld_w1, ld_w2, ld_w3;
  assign ld_w0 = ld_en_i && (ld_idx_i == IDX_W'(0));
  assign ld_w1 = ld_en_i && (ld_idx_i == IDX_W'(1));
  assign ld_w2 = ld_en_i && (ld_idx_i == IDX_W'(2));
  assign ld_w3 = ld_en_i && (ld_idx_i == IDX_W'(3));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_o   <= '0;
      branch_o <= '0;
      src_o    <= '0;
      id_o     <= '0;
      cmd_o    <= '0;
    end else begin
      // fetched pointer wins over a software write in the same cycle
      if (ld_w0)                      next_o <= ld_data_i & ALIGN_MASK;
      else if (wr_en_i && !wr_sel_i)  next_o <= wr_data_i & ALIGN_MASK;

      if (wr_en_i && wr_sel_i)        branch_o <= wr_data_i & BR_MASK;
      else if (clr_bra_i)             branch_o[BR_REQ_BIT] <= 1'b0;

      if (ld_w1)                      src_o <= ld_data_i;
      else if (clr_src_i)             src_o <= '0;

      if (ld_w2)                      id_o  <= ld_data_i;
      if (ld_w3)                      cmd_o <= ld_data_i;
    end
  end
endmodule

// File: rtl/frame_desc_fetch.sv
module frame_desc_fetch import fdf_pkg::*; #(
  parameter int unsigned              AW       = 32,
  parameter int unsigned              NUM_WIN  = 2,
  parameter logic [NUM_WIN*AW-1:0]    WIN_BASE = {32'h5C00_0000, 32'hA000_0000},
  parameter logic [NUM_WIN*AW-1:0]    WIN_SIZE = {32'h0004_0000, 32'h0400_0000},
  parameter int unsigned              CH_W     = 3,
  parameter int unsigned              CH_ID    = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            chan_en_i,
  input  logic            frame_start_i,
  input  logic            frame_done_i,
  input  logic            reg_we_i,
  input  logic            reg_sel_i,
  input  logic [AW-1:0]   reg_wdata_i,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [AW-1:0]   mem_rdata_i,
  output logic            busy_o,
  output logic [AW-1:0]   next_desc_o,
  output logic [AW-1:0]   branch_o,
  output logic [AW-1:0]   src_addr_o,
  output logic [AW-1:0]   frame_id_o,
  output logic [AW-1:0]   cmd_o,
  output logic            xfer_go_o,
  output logic            pal_go_o,
  output logic            ev_sof_o,
  output logic            ev_eof_o,
  output logic            ev_bs_o,
  output logic            ev_ber_o,
  output logic [CH_W-1:0] ber_chan_o
);
  localparam int unsigned IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  fdf_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [AW-1:0]    base_q;

  logic             start_ok, fetch_go, use_br, ld_en;
  logic [AW-1:0]    pick_addr;
  logic [NUM_WIN-1:0] desc_hit_v, src_hit_v;
  logic             desc_hit, src_ok;

  assign start_ok  = frame_start_i && (state_q == ST_IDLE);
  assign fetch_go  = start_ok && chan_en_i;
  assign use_br    = branch_o[BR_REQ_BIT];
  assign pick_addr = use_br ? {branch_o[AW-1:4], 4'b0000} : next_desc_o;
  assign ld_en     = (state_q == ST_FETCH) && mem_rvalid_i;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    fdf_win_chk #(
      .AW(AW), .BASE(WIN_BASE[g*AW +: AW]), .SIZE(WIN_SIZE[g*AW +: AW]),
      .SPAN(DESC_BYTES)
    ) u_desc_win (.addr_i(pick_addr), .hit_o(desc_hit_v[g]));

    fdf_win_chk #(
      .AW(AW), .BASE(WIN_BASE[g*AW +: AW]), .SIZE(WIN_SIZE[g*AW +: AW]),
      .SPAN(1)
    ) u_src_win (.addr_i(src_addr_o), .hit_o(src_hit_v[g]));
  end

  assign desc_hit = |desc_hit_v;
  assign src_ok   = (src_addr_o != '0) && (|src_hit_v);

  fdf_desc_regs #(.AW(AW), .IDX_W(IDX_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (reg_we_i),
    .wr_sel_i  (reg_sel_i),
    .wr_data_i (reg_wdata_i),
    .clr_src_i (start_ok),
    .clr_bra_i (fetch_go && use_br),
    .ld_en_i   (ld_en),
    .ld_idx_i  (idx_q),
    .ld_data_i (mem_rdata_i),
    .next_o    (next_desc_o),
    .branch_o  (branch_o),
    .src_o     (src_addr_o),
    .id_o      (frame_id_o),
    .cmd_o     (cmd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      base_q     <= '0;
      xfer_go_o  <= 1'b0;
      pal_go_o   <= 1'b0;
      ev_sof_o   <= 1'b0;
      ev_eof_o   <= 1'b0;
      ev_bs_o    <= 1'b0;
      ev_ber_o   <= 1'b0;
      ber_chan_o <= '0;
    end else begin
      xfer_go_o <= 1'b0;
      pal_go_o  <= 1'b0;
      ev_sof_o  <= 1'b0;
      ev_eof_o  <= 1'b0;
      ev_bs_o   <= 1'b0;
      ev_ber_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (fetch_go) begin
            base_q  <= pick_addr;
            idx_q   <= '0;
            ev_bs_o <= use_br && branch_o[BR_INT_BIT];
            // skipped fetch goes straight to the check with a zero source
            state_q <= desc_hit ? ST_FETCH : ST_CHECK;
          end
        end
        ST_FETCH: begin
          if (mem_rvalid_i) begin
            idx_q <= idx_q + IDX_W'(1);
            if (idx_q == LAST_IDX) state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!src_ok) begin
            ev_ber_o   <= 1'b1;
            ber_chan_o <= CH_W'(CH_ID);
            state_q    <= ST_IDLE;
          end else if (cmd_o[CMD_PAL_BIT]) begin
            pal_go_o <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            xfer_go_o <= 1'b1;
            ev_sof_o  <= cmd_o[CMD_SOF_BIT];
            state_q   <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (frame_done_i) begin
            ev_eof_o <= cmd_o[CMD_EOF_BIT];
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_FETCH);
  assign busy_o     = (state_q == ST_FETCH);
  assign mem_addr_o = base_q + AW'({idx_q, 2'b00});
endmodule

// File: rtl/fdf_checker.sv
module fdf_checker import fdf_pkg::*; #(
  parameter int unsigned           AW       = 32,
  parameter int unsigned           NUM_WIN  = 2,
  parameter logic [NUM_WIN*AW-1:0] WIN_BASE = '0,
  parameter logic [NUM_WIN*AW-1:0] WIN_SIZE = '0,
  parameter int unsigned           CH_W     = 3,
  parameter int unsigned           CH_ID    = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_req_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic            mem_rvalid_i,
  input logic            busy_o,
  input logic [AW-1:0]   next_desc_o,
  input logic [AW-1:0]   branch_o,
  input logic [AW-1:0]   src_addr_o,
  input logic [AW-1:0]   cmd_o,
  input logic            xfer_go_o,
  input logic            pal_go_o,
  input logic            ev_sof_o,
  input logic            ev_eof_o,
  input logic            ev_bs_o,
  input logic            ev_ber_o,
  input logic [CH_W-1:0] ber_chan_o
);
  logic req_in_win;
  always_comb begin
    req_in_win = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (({1'b0, mem_addr_o} >= {1'b0, WIN_BASE[w*AW +: AW]}) &&
          ({1'b0, mem_addr_o} + (AW+1)'(4) <=
           {1'b0, WIN_BASE[w*AW +: AW]} + {1'b0, WIN_SIZE[w*AW +: AW]}))
        req_in_win = 1'b1;
    end
  end

  AST_REQ_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> req_in_win);  // R5
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));  // R10
  AST_BS_FROM_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_bs_o |-> ($past(branch_o[1:0]) == 2'b11));  // R3
  AST_NEXT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_desc_o[3:0] == 4'h0);  // R4
  AST_BRANCH_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_o[3:2] == 2'b00);  // R2
  AST_SRC_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (src_addr_o == '0));  // R6
  AST_BER_TAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_ber_o |-> (ber_chan_o == CH_W'(CH_ID) && !xfer_go_o && !pal_go_o));  // R7
  AST_SOF_WITH_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_sof_o |-> (xfer_go_o && cmd_o[CMD_SOF_BIT] && !cmd_o[CMD_PAL_BIT]));  // R8
  AST_EOF_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_eof_o |-> (cmd_o[CMD_EOF_BIT] && !ev_sof_o && !busy_o));  // R8
  AST_PAL_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_go_o |-> (cmd_o[CMD_PAL_BIT] && !ev_sof_o && !xfer_go_o));  // R9
endmodule

bind frame_desc_fetch fdf_checker #(
  .AW(AW), .NUM_WIN(NUM_WIN), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE),
  .CH_W(CH_W), .CH_ID(CH_ID)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i), .busy_o(busy_o), .next_desc_o(next_desc_o),
  .branch_o(branch_o), .src_addr_o(src_addr_o), .cmd_o(cmd_o),
  .xfer_go_o(xfer_go_o), .pal_go_o(pal_go_o), .ev_sof_o(ev_sof_o),
  .ev_eof_o(ev_eof_o), .ev_bs_o(ev_bs_o), .ev_ber_o(ev_ber_o),
  .ber_chan_o(ber_chan_o)
);

// File: tb/sim_frame_desc_fetch.sv
`timescale 1ns/1ps
module sim_frame_desc_fetch;
  localparam int K_BS = 1, K_BER = 2, K_SOF = 3, K_XFER = 4, K_PAL = 5, K_EOF = 6;
  localparam int LAT = 2;
  localparam logic [2:0] CHAN = 3'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chan_en = 1'b1, fs = 1'b0, fd = 1'b0, we = 1'b0, sel = 1'b0;
  logic [31:0] wdata = '0;
  logic mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic busy, xfer_go, pal_go, ev_sof, ev_eof, ev_bs, ev_ber;
  logic [31:0] next_desc, branch, src_addr, frame_id, cmd;
  logic [2:0] ber_chan;

  int checks = 0, failures = 0;
  int exp_q[$];
  logic [31:0] mem [logic [31:0]];
  bit req_seen = 1'b0;

  always #10 clk = ~clk;

  frame_desc_fetch #(.CH_ID(3)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .chan_en_i(chan_en), .frame_start_i(fs),
    .frame_done_i(fd), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .next_desc_o(next_desc),
    .branch_o(branch), .src_addr_o(src_addr), .frame_id_o(frame_id), .cmd_o(cmd),
    .xfer_go_o(xfer_go), .pal_go_o(pal_go), .ev_sof_o(ev_sof), .ev_eof_o(ev_eof),
    .ev_bs_o(ev_bs), .ev_ber_o(ev_ber), .ber_chan_o(ber_chan)
  );

  function automatic string kreq(int k);
    case (k)
      K_BS: return "R3";
      K_BER: return "R7";
      K_PAL: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pop_cmp(int k);
    checks++;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL %s actual=event%0d expected=none", kreq(k), k);
    end else begin
      int got = exp_q.pop_front();
      if (got != k) begin
        failures++;
        $display("FAIL %s actual=event%0d expected=event%0d", kreq(got), k, got);
      end
    end
  endtask

  // monitor: compare each pulsed event against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (ev_bs)   pop_cmp(K_BS);
      if (ev_ber) begin
        pop_cmp(K_BER);
        chk("R7 chan", {29'd0, ber_chan}, {29'd0, CHAN});
      end
      if (ev_sof)  pop_cmp(K_SOF);
      if (xfer_go) pop_cmp(K_XFER);
      if (pal_go)  pop_cmp(K_PAL);
      if (ev_eof)  pop_cmp(K_EOF);
    end
  end

  // memory responder: fixed latency, one word per request
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        req_seen = 1'b1;
        cnt++;
        if (cnt == LAT) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
          cnt = 0;
        end
      end else cnt = 0;
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(logic s, logic [31:0] d);
    @(negedge clk); we = 1'b1; sel = s; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask
  task automatic pulse_start; @(negedge clk); fs = 1'b1; @(negedge clk); fs = 1'b0; endtask
  task automatic pulse_done;  @(negedge clk); fd = 1'b1; @(negedge clk); fd = 1'b0; endtask
  task automatic put_desc(logic [31:0] a, logic [31:0] n, logic [31:0] s,
                          logic [31:0] i, logic [31:0] c);
    mem[a] = n; mem[a+4] = s; mem[a+8] = i; mem[a+12] = c;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    put_desc(32'hA000_0100, 32'hA000_0205, 32'hA000_1000, 32'h11, (1<<22)|(1<<21)|32'h40);
    put_desc(32'hA000_0200, 32'hA000_0100, 32'hA000_2000, 32'h22, 32'h80);
    put_desc(32'hA000_0300, 32'hA000_0100, 32'h5C00_0010, 32'h33, 1<<21);
    put_desc(32'hA3FF_FFF0, 32'hA000_0100, 32'h0,         32'h44, 1<<22);
    put_desc(32'hA000_0400, 32'hA000_0100, 32'h0000_1000, 32'h55, 1<<22);
    put_desc(32'hA000_0500, 32'hA000_0100, 32'hA000_3000, 32'h66, (1<<26)|(1<<22)|(1<<21));

    tick(3); rst_n = 1'b1; tick(1);
    chk("R10 reset busy", {31'd0, busy}, 32'd0);
    chk("R10 reset req", {31'd0, mem_req}, 32'd0);
    chk("R6 reset src", src_addr, 32'h0);
    chk("R2 reset branch", branch, 32'h0);

    wr(1'b0, 32'hA000_0107);
    chk("R4 next write aligned", next_desc, 32'hA000_0100);
    wr(1'b1, 32'hFFFF_FFFF);
    chk("R2 branch mask", branch, 32'hFFFF_FFF3);
    wr(1'b1, 32'h0);

    // plain frame with both interrupts
    exp_q.push_back(K_SOF); exp_q.push_back(K_XFER);
    pulse_start;
    chk("R10 busy after start", {31'd0, busy}, 32'd1);
    chk("R1 first word address", mem_addr, 32'hA000_0100);
    tick(16);
    chk("R1 R4 next latched", next_desc, 32'hA000_0200);
    chk("R1 source latched", src_addr, 32'hA000_1000);
    chk("R1 id latched", frame_id, 32'h11);
    chk("R1 cmd latched", cmd, (1<<22)|(1<<21)|32'h40);
    chk("R10 busy after fetch", {31'd0, busy}, 32'd0);
    exp_q.push_back(K_EOF);
    pulse_done; tick(2);

    // chained frame, no interrupts
    exp_q.push_back(K_XFER);
    pulse_start; tick(16);
    chk("R1 chained id", frame_id, 32'h22);
    pulse_done; tick(2);

    // branch with interrupt
    wr(1'b1, 32'hA000_0303);
    exp_q.push_back(K_BS); exp_q.push_back(K_XFER);
    pulse_start;
    chk("R3 branch address used", mem_addr, 32'hA000_0300);
    tick(16);
    chk("R3 request bit cleared", branch, 32'hA000_0302);
    chk("R3 branch id", frame_id, 32'h33);
    exp_q.push_back(K_EOF);
    pulse_done; tick(2);

    // branch without interrupt, source outside windows
    wr(1'b1, 32'hA000_0401);
    exp_q.push_back(K_BER);
    pulse_start; tick(16);
    chk("R3 no-int branch id", frame_id, 32'h55);
    chk("R3 branch cleared", branch, 32'hA000_0400);

    // descriptor just past window end: skipped
    wr(1'b0, 32'hA400_0000);
    req_seen = 1'b0;
    exp_q.push_back(K_BER);
    pulse_start;
    chk("R10 busy low on skip", {31'd0, busy}, 32'd0);
    tick(8);
    chk("R5 no request on skip", {31'd0, req_seen}, 32'd0);
    chk("R5 source stays zero", src_addr, 32'h0);

    // descriptor ending exactly at window end: fetched, zero source
    wr(1'b0, 32'hA3FF_FFF0);
    req_seen = 1'b0;
    exp_q.push_back(K_BER);
    pulse_start; tick(16);
    chk("R5 boundary fetch", {31'd0, req_seen}, 32'd1);
    chk("R7 boundary id", frame_id, 32'h44);

    // palette frame
    wr(1'b0, 32'hA000_0500);
    exp_q.push_back(K_PAL);
    pulse_start; tick(16);
    chk("R9 palette source", src_addr, 32'hA000_3000);
    pulse_done; tick(3);

    // disabled channel
    chan_en = 1'b0; req_seen = 1'b0;
    pulse_start; tick(8);
    chk("R6 source cleared when disabled", src_addr, 32'h0);
    chk("R6 no request when disabled", {31'd0, req_seen}, 32'd0);
    chan_en = 1'b1;

    // second start during fetch ignored
    wr(1'b0, 32'hA000_0100);
    exp_q.push_back(K_SOF); exp_q.push_back(K_XFER);
    pulse_start; tick(2);
    pulse_start; tick(16);
    chk("R10 id after ignored start", frame_id, 32'h11);
    exp_q.push_back(K_EOF);
    pulse_done; tick(2);
    pulse_done; tick(4);

    chk("R8 scoreboard drained", exp_q.size(), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule